// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock calendar time as seven separate fields: second, minute, hour, day of week, day of month, month and a two-digit year. The fields are advanced by a one-second tick pulse supplied from outside. A carry ripples from seconds up through the year, and the block handles month lengths and leap years. The year is a relative count from 0 to 99 that wraps back to 0. Year 0 is deliberately not treated as a leap year.

Software reaches every field, and one control word, through a simple word-addressed register port. Reads are combinational. Writes take effect at the next clock edge. A stop bit in the control word freezes counting, so that software can load a new time without the fields moving underneath it. Clearing the bit resumes counting from the loaded value.

Fields may change between two reads. A reader that needs a coherent snapshot reads the second field first and last, and retries if the two values differ.

Top module: `cal_counter`

## Requirements
- R1: After reset, second, minute, hour and day of week read 0, day of month and month read 1, year reads 0, and the control word reads 1 (stopped).
- R2: The control word is at byte address 0x20, and its bit 0 is the stop bit. The fields are at 0x40 (year), 0x44 (month), 0x48 (day of month), 0x4C (day of week), 0x50 (hour), 0x54 (minute) and 0x58 (second). Reads are zero-extended to 32 bits. Any other address, misaligned ones included, reads 0, and a write to it changes nothing.
- R3: A write to a field address stores the low bits of the write data at the next clock edge. The widths kept are: second 6, minute 6, hour 5, day of month 5, day of week 3, month 4, year 7.
- R4: While the stop bit is 1, ticks leave every field unchanged.
- R5: With the stop bit at 0, a tick advances the second by one at the next clock edge. Without a tick or a write, nothing changes.
- R6: The second rolls from 59 to 0 and carries into the minute. The minute rolls from 59 to 0 and carries into the hour. The hour rolls from 23 to 0 and carries into the day.
- R7: On a day carry, the day of week advances, and it wraps from 6 to 0.
- R8: On a day carry, the day of month rolls to 1 after the last day of the month and advances the month. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, months 4, 6, 9 and 11 have 30, and February has 28 or 29. The month wraps from 12 to 1 and carries into the year.
- R9: February has 29 days in years divisible by 4, except year 0, which has 28.
- R10: A year carry takes year 99 to 0, and every other year to the next year.
- R11: When a write and a tick fall in the same cycle, the write is applied and the tick is discarded: no field advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 8 | Byte address of the accessed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |

## Verification
The carry chain is driven from loaded boundary times. The first is a single year-end tick at 23:59:59 on the 31st of December of year 99, which separates a full ripple through every field from a partial one. February 28 ticks in years 0, 4 and 21 tell the leap rule and its year-0 exception from a plain modulo-4 test. A February 29 tick and the ends of 30-day and 31-day months tell the month-length table apart. Ticks against a set stop bit, writes to unmapped and misaligned addresses, and a write landing in the same cycle as a tick show that only the intended path moves the state.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DOW_W  = 3;
    localparam int DOM_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int DOW_LAST  = 6;
    localparam int MON_LAST  = 12;
    localparam int YEAR_LAST = 99;

    // Word order at the field window; software depends on it.
    typedef enum logic [2:0] {
        FLD_YEAR = 3'd0,
        FLD_MON  = 3'd1,
        FLD_DOM  = 3'd2,
        FLD_DOW  = 3'd3,
        FLD_HOUR = 3'd4,
        FLD_MIN  = 3'd5,
        FLD_SEC  = 3'd6
    } cal_field_e;

    localparam int NUM_FIELDS = 7;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DOM_W-1:0]  dom;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{
        year: '0, mon: MON_W'(1), dom: DOM_W'(1), dow: '0,
        hour: '0, minute: '0, sec: '0
    };

    // Year 0 is excluded on purpose.
    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'b00) && (y != '0);
    endfunction

    function automatic logic [DOM_W-1:0] days_in(input logic [MON_W-1:0] m,
                                                 input logic leap);
        logic [DOM_W-1:0] d;
        case (m)
            MON_W'(2):                        d = leap ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):            d = DOM_W'(30);
            default:                          d = DOM_W'(31);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cal_bus_decode.sv
module cal_bus_decode
    import cal_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CTRL_OFF   = 'h20,
    parameter int FIELD_BASE = 'h40
) (
    input  logic [ADDR_W-1:0]     addr_i,
    output logic                  ctrl_hit_o,
    output logic [NUM_FIELDS-1:0] field_hit_o
);

    localparam int STRIDE = 4;

    assign ctrl_hit_o = (addr_i == ADDR_W'(CTRL_OFF));

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign field_hit_o[i] = (addr_i == ADDR_W'(FIELD_BASE + STRIDE * i));
    end

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  logic [MON_W-1:0]  mon_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic [DOM_W-1:0]  last_day_o
);

    logic leap;

    assign leap       = is_leap(year_i);
    assign last_day_o = days_in(mon_i, leap);

endmodule

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_time_t cur_i,
    output cal_time_t nxt_o
);

    logic [DOM_W-1:0] last_day;
    logic             c_min, c_hour, c_day, c_mon, c_year;

    cal_month_len u_mlen (
        .mon_i      (cur_i.mon),
        .year_i     (cur_i.year),
        .last_day_o (last_day)
    );

    // Carries: each stage wraps when at (or beyond) its last value.
    assign c_min  = (cur_i.sec    >= SEC_W'(SEC_LAST));
    assign c_hour = c_min  && (cur_i.minute >= MIN_W'(MIN_LAST));
    assign c_day  = c_hour && (cur_i.hour   >= HOUR_W'(HOUR_LAST));
    assign c_mon  = c_day  && (cur_i.dom    >= last_day);
    assign c_year = c_mon  && (cur_i.mon    >= MON_W'(MON_LAST));

    always_comb begin
        nxt_o = cur_i;

        nxt_o.sec = c_min ? '0 : cur_i.sec + SEC_W'(1);

        if (c_min)
            nxt_o.minute = c_hour ? '0 : cur_i.minute + MIN_W'(1);

        if (c_hour)
            nxt_o.hour = c_day ? '0 : cur_i.hour + HOUR_W'(1);

        if (c_day) begin
            nxt_o.dow = (cur_i.dow >= DOW_W'(DOW_LAST)) ? '0 : cur_i.dow + DOW_W'(1);
            nxt_o.dom = c_mon ? DOM_W'(1) : cur_i.dom + DOM_W'(1);
        end

        if (c_mon)
            nxt_o.mon = c_year ? MON_W'(1) : cur_i.mon + MON_W'(1);

        if (c_year)
            nxt_o.year = (cur_i.year >= YEAR_W'(YEAR_LAST)) ? '0 : cur_i.year + YEAR_W'(1);
    end

endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CTRL_OFF   = 'h20,
    parameter int FIELD_BASE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    cal_time_t             t_q, t_d, t_nxt;
    logic                  stop_q, stop_d;
    logic                  ctrl_hit;
    logic [NUM_FIELDS-1:0] field_hit;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DATA_W-1:YEAR_W];

    cal_bus_decode #(
        .ADDR_W     (ADDR_W),
        .CTRL_OFF   (CTRL_OFF),
        .FIELD_BASE (FIELD_BASE)
    ) u_dec (
        .addr_i      (bus_addr_i),
        .ctrl_hit_o  (ctrl_hit),
        .field_hit_o (field_hit)
    );

    cal_step u_step (
        .cur_i (t_q),
        .nxt_o (t_nxt)
    );

    // A bus write owns the cycle; a coincident tick is dropped.
    always_comb begin
        t_d    = t_q;
        stop_d = stop_q;
        if (bus_wr_i) begin
            if (ctrl_hit)                 stop_d     = bus_wdata_i[0];
            if (field_hit[int'(FLD_YEAR)]) t_d.year   = bus_wdata_i[YEAR_W-1:0];
            if (field_hit[int'(FLD_MON)])  t_d.mon    = bus_wdata_i[MON_W-1:0];
            if (field_hit[int'(FLD_DOM)])  t_d.dom    = bus_wdata_i[DOM_W-1:0];
            if (field_hit[int'(FLD_DOW)])  t_d.dow    = bus_wdata_i[DOW_W-1:0];
            if (field_hit[int'(FLD_HOUR)]) t_d.hour   = bus_wdata_i[HOUR_W-1:0];
            if (field_hit[int'(FLD_MIN)])  t_d.minute = bus_wdata_i[MIN_W-1:0];
            if (field_hit[int'(FLD_SEC)])  t_d.sec    = bus_wdata_i[SEC_W-1:0];
        end else if (tick_i && !stop_q) begin
            t_d = t_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q    <= CAL_RESET;
            stop_q <= 1'b1;
        end else begin
            t_q    <= t_d;
            stop_q <= stop_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (ctrl_hit)                  bus_rdata_o = DATA_W'(stop_q);
        if (field_hit[int'(FLD_YEAR)]) bus_rdata_o = DATA_W'(t_q.year);
        if (field_hit[int'(FLD_MON)])  bus_rdata_o = DATA_W'(t_q.mon);
        if (field_hit[int'(FLD_DOM)])  bus_rdata_o = DATA_W'(t_q.dom);
        if (field_hit[int'(FLD_DOW)])  bus_rdata_o = DATA_W'(t_q.dow);
        if (field_hit[int'(FLD_HOUR)]) bus_rdata_o = DATA_W'(t_q.hour);
        if (field_hit[int'(FLD_MIN)])  bus_rdata_o = DATA_W'(t_q.minute);
        if (field_hit[int'(FLD_SEC)])  bus_rdata_o = DATA_W'(t_q.sec);
    end

endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk
    import cal_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIELD_BASE = 'h40
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [SEC_W-1:0]  wr_sec,
    input cal_time_t         t_q,
    input logic              stop_q
);

    localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(FIELD_BASE + 4 * int'(FLD_SEC));

    logic advance;
    assign advance = tick_i && !stop_q && !bus_wr_i;

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !bus_wr_i) |=> ($stable(t_q) && $stable(stop_q)));

    p_stop_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !bus_wr_i) |=> $stable(t_q));

    p_sec_step_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && t_q.sec < SEC_W'(SEC_LAST)) |=> (t_q.sec == $past(t_q.sec) + SEC_W'(1)));

    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && t_q.sec == SEC_W'(SEC_LAST) && t_q.minute < MIN_W'(MIN_LAST))
        |=> (t_q.sec == '0 && t_q.minute == $past(t_q.minute) + MIN_W'(1)));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && tick_i && bus_addr_i == SEC_ADDR)
        |=> (t_q.sec == $past(wr_sec) && $stable(t_q.minute)));

    p_year_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (advance && t_q.year == YEAR_W'(YEAR_LAST) && t_q.mon == MON_W'(12)
         && t_q.dom == DOM_W'(31) && t_q.hour == HOUR_W'(HOUR_LAST)
         && t_q.minute == MIN_W'(MIN_LAST) && t_q.sec == SEC_W'(SEC_LAST))
        |=> (t_q.year == '0 && t_q.mon == MON_W'(1)));

endmodule

bind cal_counter cal_counter_chk #(
    .ADDR_W     (ADDR_W),
    .FIELD_BASE (FIELD_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .wr_sec     (bus_wdata_i[cal_pkg::SEC_W-1:0]),
    .t_q        (t_q),
    .stop_q     (stop_q)
);

// File: tb/cal_counter_tb.sv
module cal_counter_tb;

    localparam int CLK_NS = 8;

    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_YEAR = 8'h40;
    localparam logic [7:0] A_MON  = 8'h44;
    localparam logic [7:0] A_DOM  = 8'h48;
    localparam logic [7:0] A_DOW  = 8'h4C;
    localparam logic [7:0] A_HOUR = 8'h50;
    localparam logic [7:0] A_MIN  = 8'h54;
    localparam logic [7:0] A_SEC  = 8'h58;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_NS/2) clk = ~clk;

    cal_counter u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    // Monitor: compares the read data one step after the edge that follows a request.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=0x%02h actual=0x%0h expected=0x%0h",
                             it.tag, it.addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        addr = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic load_time(input int y, input int mo, input int d, input int w,
                             input int h, input int mi, input int s);
        bus_write(A_CTRL, 32'd1);
        bus_write(A_YEAR, 32'(y));
        bus_write(A_MON,  32'(mo));
        bus_write(A_DOM,  32'(d));
        bus_write(A_DOW,  32'(w));
        bus_write(A_HOUR, 32'(h));
        bus_write(A_MIN,  32'(mi));
        bus_write(A_SEC,  32'(s));
        bus_write(A_CTRL, 32'd0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(A_CTRL, 32'd1, "R1 ctrl");
        expect_rd(A_SEC,  32'd0, "R1 sec");
        expect_rd(A_HOUR, 32'd0, "R1 hour");
        expect_rd(A_DOW,  32'd0, "R1 dow");
        expect_rd(A_DOM,  32'd1, "R1 dom");
        expect_rd(A_MON,  32'd1, "R1 mon");
        expect_rd(A_YEAR, 32'd0, "R1 year");

        // R4 ticks ignored while stopped
        ticks(3);
        expect_rd(A_SEC, 32'd0, "R4 stopped sec");

        // R5 counting after stop cleared
        bus_write(A_CTRL, 32'd0);
        expect_rd(A_CTRL, 32'd0, "R2 ctrl cleared");
        ticks(3);
        expect_rd(A_SEC, 32'd3, "R5 three ticks");
        repeat (5) @(negedge clk);
        expect_rd(A_SEC, 32'd3, "R5 idle hold");

        // R2 unmapped and misaligned addresses
        expect_rd(8'h30, 32'd0, "R2 unmapped read");
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'h5A, 32'd7);
        expect_rd(A_SEC, 32'd3, "R2 stray writes ignored");
        expect_rd(A_MIN, 32'd0, "R2 stray writes ignored min");

        // R3 write truncation to field width
        bus_write(A_SEC, 32'hFFFF_FFC5);
        expect_rd(A_SEC, 32'd5, "R3 sec truncation");
        bus_write(A_DOW, 32'h0000_000D);
        expect_rd(A_DOW, 32'd5, "R3 dow truncation");

        // R6 R7 R8 R10 full ripple at year end
        load_time(99, 12, 31, 6, 23, 59, 59);
        ticks(1);
        expect_rd(A_SEC,  32'd0, "R6 sec wrap");
        expect_rd(A_MIN,  32'd0, "R6 min wrap");
        expect_rd(A_HOUR, 32'd0, "R6 hour wrap");
        expect_rd(A_DOW,  32'd0, "R7 dow wrap");
        expect_rd(A_DOM,  32'd1, "R8 dom wrap");
        expect_rd(A_MON,  32'd1, "R8 mon wrap");
        expect_rd(A_YEAR, 32'd0, "R10 year wrap");

        // R9 year 0 February is 28 days
        load_time(0, 2, 28, 1, 23, 59, 59);
        ticks(1);
        expect_rd(A_DOM, 32'd1, "R9 year0 feb dom");
        expect_rd(A_MON, 32'd3, "R9 year0 feb mon");

        // R9 year 4 February has a 29th
        load_time(4, 2, 28, 1, 23, 59, 59);
        ticks(1);
        expect_rd(A_DOM, 32'd29, "R9 leap feb28");
        expect_rd(A_MON, 32'd2,  "R9 leap feb28 mon");
        load_time(4, 2, 29, 2, 23, 59, 59);
        ticks(1);
        expect_rd(A_DOM, 32'd1, "R9 leap feb29 dom");
        expect_rd(A_MON, 32'd3, "R9 leap feb29 mon");
        expect_rd(A_DOW, 32'd3, "R7 dow step");

        // R9 non-leap year 21
        load_time(21, 2, 28, 0, 23, 59, 59);
        ticks(1);
        expect_rd(A_MON, 32'd3, "R9 plain feb mon");

        // R8 month lengths
        load_time(10, 4, 30, 0, 23, 59, 59);
        ticks(1);
        expect_rd(A_DOM, 32'd1, "R8 april end dom");
        expect_rd(A_MON, 32'd5, "R8 april end mon");
        load_time(10, 1, 30, 0, 23, 59, 59);
        ticks(1);
        expect_rd(A_DOM, 32'd31, "R8 jan30");
        load_time(10, 1, 31, 0, 23, 59, 59);
        ticks(1);
        expect_rd(A_MON, 32'd2, "R8 jan31 mon");

        // R10 ordinary year carry
        load_time(96, 12, 31, 0, 23, 59, 59);
        ticks(1);
        expect_rd(A_YEAR, 32'd97, "R10 year step");

        // R11 write beats a same-cycle tick
        load_time(50, 6, 15, 3, 10, 20, 30);
        @(negedge clk);
        wr = 1'b1; addr = A_SEC; wdata = 32'd40; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        expect_rd(A_SEC, 32'd40, "R11 sec written");
        expect_rd(A_MIN, 32'd20, "R11 min untouched");
        load_time(50, 6, 15, 3, 10, 20, 59);
        @(negedge clk);
        wr = 1'b1; addr = A_MIN; wdata = 32'd5; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        expect_rd(A_MIN,  32'd5,  "R11 min written");
        expect_rd(A_SEC,  32'd59, "R11 tick dropped");
        expect_rd(A_HOUR, 32'd10, "R11 hour untouched");

        // R4 stop again after running
        bus_write(A_CTRL, 32'd1);
        ticks(2);
        expect_rd(A_SEC,  32'd59, "R4 refrozen sec");
        expect_rd(A_CTRL, 32'd1,  "R4 ctrl set");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule